// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Fabric

This block moves packets from any of `PORTS` inputs to any of `PORTS` outputs through a multistage network of two-by-two switches. `PORTS` is a power of two. There are `log2(PORTS)` stages. Ahead of each stage the lines are reordered by a perfect shuffle: line `i` moves to the position given by rotating the bits of `i` one place to the left. Each input presents a valid flag, a destination index and a payload.

The fabric needs no central controller. Each switch looks at one destination bit per packet. Stage 0 uses the most significant bit, and each later stage uses the next lower bit. From that bit the switch chooses straight or crossed. A packet whose bit is 0 leaves on the switch's even line, and a packet whose bit is 1 leaves on the odd line.

The network is blocking. When two packets in one switch need the same output line, the packet from the lower-numbered input goes on and the other packet is dropped. The dropped packet's input is flagged in a blocked vector. The routing path is combinational. Delivered packets, their source indices and the blocked vector are registered once, so results appear one clock after the inputs are presented.

Top module: `omega_fabric`

## Requirements
- R1: While reset is asserted, every output (`out_valid`, `out_data`, `out_src`, `blocked`) is zero, whatever the inputs are.
- R2: A lone valid packet on input `s` with destination `d` appears on output `d`, with its payload and `out_src` = `s`, for every pair (`s`, `d`).
- R3: The fabric's inputs reach its outputs with exactly one clock of latency. Outputs do not change between clock edges.
- R4: An output that receives no packet shows `out_valid` 0, payload 0 and source 0.
- R5: When two valid packets need the same switch output, the packet with the lower input index proceeds. For example, with 8 ports, 2→7 and 6→4 collide in the first stage: output 7 delivers source 2, and input 6 is blocked.
- R6: `blocked[i]` is 1 one cycle after input `i` presented a valid packet that lost a conflict. It is 0 for inputs that were not valid.
- R7: Conflict-free patterns deliver every packet with no blocked flag. These include the identity permutation and every cyclic shift `d = (s + c) mod PORTS`.
- R8: Every valid packet is accounted for exactly once: the delivered count plus the blocked count equals the number of valid inputs in the previous cycle.
- R9: The destination and payload of an input whose valid flag is 0 have no effect on any output.
- R10: A packet shown on output `o` always came from an input whose destination was `o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | PORTS | Per-input packet present flag |
| in_dest | input | PORTS*log2(PORTS) | Destination index of each input, input `i` in slice `i` |
| in_data | input | PORTS*DATA_W | Payload of each input, input `i` in slice `i` |
| out_valid | output | PORTS | Per-output packet delivered flag (registered) |
| out_data | output | PORTS*DATA_W | Payload delivered on each output, zero when idle |
| out_src | output | PORTS*log2(PORTS) | Input index of the packet on each output, zero when idle |
| blocked | output | PORTS | Per-input flag: that input's packet was dropped in a conflict |

## Verification
The hardest case to reach from the ports is a conflict deep inside the network, in the second or last stage, rather than at the first. In such a case the two packets did not meet earlier, so no earlier switch resolves the conflict. Long runs of random destinations with all inputs valid produce such collisions at every stage. The bench also replays the known first-stage collision, and it checks conflict-free shifts to show that no false block arises. A behavioural path-tracing model predicts every output and blocked flag each clock.

// File: rtl/omega_pkg.sv
package omega_pkg;

   typedef enum logic {
      SW_STRAIGHT = 1'b0,
      SW_SWAPPED  = 1'b1
   } sw_mode_e;

   // one-bit left rotation of a w-bit line index
   function automatic int unsigned shuffle_idx(input int unsigned idx, input int unsigned w);
      int unsigned mask;
      mask = (32'd1 << w) - 32'd1;
      return ((idx << 1) | (idx >> (w - 1))) & mask;
   endfunction

endpackage

// File: rtl/omega_sw.sv
module omega_sw
   import omega_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16,
   parameter int BIT    = 2
) (
   input  logic              a_vld,
   input  logic [ADDR_W-1:0] a_dst,
   input  logic [ADDR_W-1:0] a_src,
   input  logic [DATA_W-1:0] a_dat,
   input  logic              b_vld,
   input  logic [ADDR_W-1:0] b_dst,
   input  logic [ADDR_W-1:0] b_src,
   input  logic [DATA_W-1:0] b_dat,
   output logic              e_vld,
   output logic [ADDR_W-1:0] e_dst,
   output logic [ADDR_W-1:0] e_src,
   output logic [DATA_W-1:0] e_dat,
   output logic              o_vld,
   output logic [ADDR_W-1:0] o_dst,
   output logic [ADDR_W-1:0] o_src,
   output logic [DATA_W-1:0] o_dat,
   output logic              drop_vld,
   output logic [ADDR_W-1:0] drop_src
);

   logic     a_want, b_want, clash, a_first, a_go, b_go;
   sw_mode_e mode;

   assign a_want  = a_dst[BIT];
   assign b_want  = b_dst[BIT];
   assign clash   = a_vld & b_vld & (a_want == b_want);
   assign a_first = (a_src < b_src);
   assign a_go    = a_vld & (~clash | a_first);
   assign b_go    = b_vld & (~clash | ~a_first);

   always_comb begin
      if (a_go)      mode = a_want ? SW_SWAPPED : SW_STRAIGHT;
      else if (b_go) mode = b_want ? SW_STRAIGHT : SW_SWAPPED;
      else           mode = SW_STRAIGHT;
   end

   always_comb begin
      e_vld = 1'b0; e_dst = '0; e_src = '0; e_dat = '0;
      o_vld = 1'b0; o_dst = '0; o_src = '0; o_dat = '0;
      if (mode == SW_STRAIGHT) begin
         if (a_go) begin e_vld = 1'b1; e_dst = a_dst; e_src = a_src; e_dat = a_dat; end
         if (b_go) begin o_vld = 1'b1; o_dst = b_dst; o_src = b_src; o_dat = b_dat; end
      end else begin
         if (b_go) begin e_vld = 1'b1; e_dst = b_dst; e_src = b_src; e_dat = b_dat; end
         if (a_go) begin o_vld = 1'b1; o_dst = a_dst; o_src = a_src; o_dat = a_dat; end
      end
   end

   assign drop_vld = clash;
   assign drop_src = a_first ? b_src : a_src;

endmodule

// File: rtl/omega_stage.sv
module omega_stage
   import omega_pkg::*;
#(
   parameter int PORTS  = 8,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16,
   parameter int STAGE  = 0
) (
   input  logic [PORTS-1:0]                 in_vld,
   input  logic [PORTS-1:0][ADDR_W-1:0]     in_dst,
   input  logic [PORTS-1:0][ADDR_W-1:0]     in_src,
   input  logic [PORTS-1:0][DATA_W-1:0]     in_dat,
   output logic [PORTS-1:0]                 out_vld,
   output logic [PORTS-1:0][ADDR_W-1:0]     out_dst,
   output logic [PORTS-1:0][ADDR_W-1:0]     out_src,
   output logic [PORTS-1:0][DATA_W-1:0]     out_dat,
   output logic [PORTS/2-1:0]               drop_vld,
   output logic [PORTS/2-1:0][ADDR_W-1:0]   drop_src
);

   localparam int HALF = PORTS / 2;
   localparam int BIT  = ADDR_W - 1 - STAGE;

   logic [PORTS-1:0]             sh_vld;
   logic [PORTS-1:0][ADDR_W-1:0] sh_dst;
   logic [PORTS-1:0][ADDR_W-1:0] sh_src;
   logic [PORTS-1:0][DATA_W-1:0] sh_dat;

   for (genvar r = 0; r < PORTS; r++) begin : g_shuf
      localparam int unsigned TO = shuffle_idx(r, ADDR_W);
      assign sh_vld[TO] = in_vld[r];
      assign sh_dst[TO] = in_dst[r];
      assign sh_src[TO] = in_src[r];
      assign sh_dat[TO] = in_dat[r];
   end

   for (genvar j = 0; j < HALF; j++) begin : g_sw
      omega_sw #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT(BIT)) u_sw (
         .a_vld   (sh_vld[2*j]),
         .a_dst   (sh_dst[2*j]),
         .a_src   (sh_src[2*j]),
         .a_dat   (sh_dat[2*j]),
         .b_vld   (sh_vld[2*j+1]),
         .b_dst   (sh_dst[2*j+1]),
         .b_src   (sh_src[2*j+1]),
         .b_dat   (sh_dat[2*j+1]),
         .e_vld   (out_vld[2*j]),
         .e_dst   (out_dst[2*j]),
         .e_src   (out_src[2*j]),
         .e_dat   (out_dat[2*j]),
         .o_vld   (out_vld[2*j+1]),
         .o_dst   (out_dst[2*j+1]),
         .o_src   (out_src[2*j+1]),
         .o_dat   (out_dat[2*j+1]),
         .drop_vld(drop_vld[j]),
         .drop_src(drop_src[j])
      );
   end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
   parameter int PORTS  = 8,
   parameter int DATA_W = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [PORTS-1:0]                  in_valid,
   input  logic [PORTS*$clog2(PORTS)-1:0]    in_dest,
   input  logic [PORTS*DATA_W-1:0]           in_data,
   output logic [PORTS-1:0]                  out_valid,
   output logic [PORTS*DATA_W-1:0]           out_data,
   output logic [PORTS*$clog2(PORTS)-1:0]    out_src,
   output logic [PORTS-1:0]                  blocked
);

   localparam int ADDR_W = $clog2(PORTS);
   localparam int STAGES = ADDR_W;
   localparam int HALF   = PORTS / 2;

   if (PORTS < 2 || (1 << ADDR_W) != PORTS) begin : g_bad_ports
      $error("omega_fabric: PORTS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("omega_fabric: DATA_W must be at least 1");
   end

   logic [STAGES:0][PORTS-1:0]               ln_vld;
   logic [STAGES:0][PORTS-1:0][ADDR_W-1:0]   ln_dst;
   logic [STAGES:0][PORTS-1:0][ADDR_W-1:0]   ln_src;
   logic [STAGES:0][PORTS-1:0][DATA_W-1:0]   ln_dat;
   logic [STAGES-1:0][HALF-1:0]              dr_vld;
   logic [STAGES-1:0][HALF-1:0][ADDR_W-1:0]  dr_src;
   logic [PORTS-1:0]                         blk_next;

   assign ln_vld[0] = in_valid;
   for (genvar i = 0; i < PORTS; i++) begin : g_unpack
      assign ln_dst[0][i] = in_dest[i*ADDR_W +: ADDR_W];
      assign ln_src[0][i] = ADDR_W'(i);
      assign ln_dat[0][i] = in_data[i*DATA_W +: DATA_W];
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      omega_stage #(.PORTS(PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGE(s)) u_stage (
         .in_vld  (ln_vld[s]),
         .in_dst  (ln_dst[s]),
         .in_src  (ln_src[s]),
         .in_dat  (ln_dat[s]),
         .out_vld (ln_vld[s+1]),
         .out_dst (ln_dst[s+1]),
         .out_src (ln_src[s+1]),
         .out_dat (ln_dat[s+1]),
         .drop_vld(dr_vld[s]),
         .drop_src(dr_src[s])
      );
   end

   always_comb begin
      blk_next = '0;
      for (int s = 0; s < STAGES; s++) begin
         for (int j = 0; j < HALF; j++) begin
            if (dr_vld[s][j]) blk_next[dr_src[s][j]] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= '0;
         out_data  <= '0;
         out_src   <= '0;
         blocked   <= '0;
      end else begin
         out_valid <= ln_vld[STAGES];
         out_data  <= ln_dat[STAGES];
         out_src   <= ln_src[STAGES];
         blocked   <= blk_next;
      end
   end

   // unused at the final stage: destination equals line index there
   logic unused_dst;
   assign unused_dst = ^ln_dst[STAGES];

endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
   parameter int PORTS  = 8,
   parameter int DATA_W = 16
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [PORTS-1:0]                  in_valid,
   input logic [PORTS*$clog2(PORTS)-1:0]    in_dest,
   input logic [PORTS*DATA_W-1:0]           in_data,
   input logic [PORTS-1:0]                  out_valid,
   input logic [PORTS*DATA_W-1:0]           out_data,
   input logic [PORTS*$clog2(PORTS)-1:0]    out_src,
   input logic [PORTS-1:0]                  blocked
);

   localparam int ADDR_W = $clog2(PORTS);

   logic                           primed;
   logic [PORTS-1:0]               vld_q;
   logic [PORTS*ADDR_W-1:0]        dest_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed <= 1'b0;
         vld_q  <= '0;
         dest_q <= '0;
      end else begin
         primed <= 1'b1;
         vld_q  <= in_valid;
         dest_q <= in_dest;
      end
   end

   // R8
   conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> ($countones(out_valid) + $countones(blocked)) == $countones(vld_q));

   // R6
   blocked_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (blocked & ~vld_q) == '0);

   for (genvar o = 0; o < PORTS; o++) begin : g_port
      // R4
      idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid[o] |-> (out_data[o*DATA_W +: DATA_W] == '0) && (out_src[o*ADDR_W +: ADDR_W] == '0));
      // R10
      right_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && out_valid[o]) |-> dest_q[out_src[o*ADDR_W +: ADDR_W]*ADDR_W +: ADDR_W] == ADDR_W'(o));
   end

   logic unused_in;
   assign unused_in = ^in_data;

endmodule

bind omega_fabric omega_fabric_chk #(.PORTS(PORTS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/omega_fabric_test.sv
`timescale 1ns/1ps
module omega_fabric_test;

   localparam int PORTS = 8;
   localparam int AW    = 3;
   localparam int DW    = 16;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [PORTS-1:0]    in_valid = '0;
   logic [PORTS*AW-1:0] in_dest = '0;
   logic [PORTS*DW-1:0] in_data = '0;
   logic [PORTS-1:0]    out_valid;
   logic [PORTS*DW-1:0] out_data;
   logic [PORTS*AW-1:0] out_src;
   logic [PORTS-1:0]    blocked;

   logic [PORTS-1:0]    exp_valid = '0;
   logic [PORTS*DW-1:0] exp_data = '0;
   logic [PORTS*AW-1:0] exp_src = '0;
   logic [PORTS-1:0]    exp_blk = '0;
   string               pend_tag = "R1";

   int chk_n  = 0;
   int fail_n = 0;

   always #2.5 clk = ~clk;

   omega_fabric #(.PORTS(PORTS), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .out_src(out_src), .blocked(blocked)
   );

   // behavioural path tracer: each packet's line position, stage by stage
   task automatic run_model();
      int  pos [PORTS];
      bit  live[PORTS];
      for (int i = 0; i < PORTS; i++) begin
         pos[i]  = i;
         live[i] = in_valid[i];
      end
      exp_blk = '0;
      for (int k = 0; k < AW; k++) begin
         for (int i = 0; i < PORTS; i++) begin
            if (live[i]) begin
               int r;
               r = ((pos[i] << 1) | (pos[i] >> (AW - 1))) & (PORTS - 1);
               pos[i] = (r & ~1) | int'(in_dest[i*AW + (AW - 1 - k)]);
            end
         end
         for (int i = 0; i < PORTS; i++)
            for (int j = i + 1; j < PORTS; j++)
               if (live[i] && live[j] && pos[i] == pos[j]) begin
                  live[j] = 1'b0;
                  exp_blk[j] = 1'b1;
               end
      end
      exp_valid = '0; exp_data = '0; exp_src = '0;
      for (int i = 0; i < PORTS; i++)
         if (live[i]) begin
            exp_valid[pos[i]] = 1'b1;
            exp_data[pos[i]*DW +: DW] = in_data[i*DW +: DW];
            exp_src[pos[i]*AW +: AW] = AW'(i);
         end
   endtask

   task automatic compare(input string tag);
      chk_n++;
      if (out_valid !== exp_valid || out_data !== exp_data || out_src !== exp_src || blocked !== exp_blk) begin
         fail_n++;
         $display("FAIL %s: valid=%h data=%h src=%h blk=%h expected valid=%h data=%h src=%h blk=%h",
                  tag, out_valid, out_data, out_src, blocked, exp_valid, exp_data, exp_src, exp_blk);
      end
   endtask

   task automatic cycle(input string tag, input logic [PORTS-1:0] v,
                        input logic [PORTS*AW-1:0] d, input logic [PORTS*DW-1:0] x);
      @(negedge clk);
      compare(pend_tag);
      in_valid = v; in_dest = d; in_data = x;
      run_model();
      pend_tag = tag;
   endtask

   task automatic one_pkt(input string tag, input int s, input int d, input logic [DW-1:0] x);
      logic [PORTS*AW-1:0] dd;
      logic [PORTS*DW-1:0] xx;
      dd = '0; xx = '0;
      dd[s*AW +: AW] = AW'(d);
      xx[s*DW +: DW] = x;
      cycle(tag, PORTS'(1) << s, dd, xx);
   endtask

   function automatic logic [PORTS*DW-1:0] rnd_data();
      logic [PORTS*DW-1:0] x;
      for (int i = 0; i < PORTS; i++) x[i*DW +: DW] = DW'($urandom);
      return x;
   endfunction

   function automatic logic [PORTS*AW-1:0] rnd_dest();
      logic [PORTS*AW-1:0] d;
      for (int i = 0; i < PORTS; i++) d[i*AW +: AW] = AW'($urandom);
      return d;
   endfunction

   initial begin
      #(200000 * 5);
      fail_n++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
      $finish;
   end

   initial begin
      // R1: drive traffic while in reset, outputs stay zero
      in_valid = '1;
      in_dest  = rnd_dest();
      in_data  = rnd_data();
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1");
      in_valid = '0; in_dest = '0; in_data = '0;
      run_model();
      rst_n = 1'b1;
      pend_tag = "R1";

      // R2, R4: every source to every destination, alone
      for (int s = 0; s < PORTS; s++)
         for (int d = 0; d < PORTS; d++)
            one_pkt("R2", s, d, DW'(16'hA000 + s * 16 + d));

      // R3: output unchanged until the next edge
      cycle("R4", '0, '0, '0);
      one_pkt("R3", 5, 1, 16'h5A5A);
      #1;
      chk_n++;
      if (out_valid !== '0) begin
         fail_n++;
         $display("FAIL R3: out_valid=%h expected=%h before edge", out_valid, '0);
      end

      // R5, R6: the classic first-stage collision 2->7 vs 6->4
      begin
         logic [PORTS*AW-1:0] dd;
         logic [PORTS*DW-1:0] xx;
         dd = '0; xx = '0;
         dd[2*AW +: AW] = 3'd7; xx[2*DW +: DW] = 16'h0202;
         dd[6*AW +: AW] = 3'd4; xx[6*DW +: DW] = 16'h0606;
         cycle("R5", 8'b0100_0100, dd, xx);
         @(negedge clk);
         chk_n++;
         if (!(out_valid[7] && out_src[7*AW +: AW] == 3'd2 && blocked == 8'b0100_0000)) begin
            fail_n++;
            $display("FAIL R5: valid=%h src7=%0d blk=%h expected valid7=1 src7=2 blk=40",
                     out_valid, out_src[7*AW +: AW], blocked);
         end
         chk_n++;
         if (out_valid[4] !== 1'b0) begin
            fail_n++;
            $display("FAIL R6: out_valid[4]=%b expected=0", out_valid[4]);
         end
         compare("R6");
         in_valid = '0;
         run_model();
         pend_tag = "R4";
      end

      // R7: identity and all cyclic shifts, no blocking
      for (int c = 0; c < PORTS; c++) begin
         logic [PORTS*AW-1:0] dd;
         for (int i = 0; i < PORTS; i++) dd[i*AW +: AW] = AW'((i + c) % PORTS);
         cycle("R7", '1, dd, rnd_data());
         @(negedge clk);
         chk_n++;
         if (blocked !== '0 || out_valid !== '1) begin
            fail_n++;
            $display("FAIL R7: valid=%h blk=%h expected valid=ff blk=00", out_valid, blocked);
         end
         compare("R7");
         in_valid = '0;
         run_model();
         pend_tag = "R4";
      end

      // R9: one real packet amid invalid inputs carrying garbage
      for (int n = 0; n < 40; n++) begin
         logic [PORTS*AW-1:0] dd;
         int s;
         s  = $urandom % PORTS;
         dd = rnd_dest();
         cycle("R9", PORTS'(1) << s, dd, rnd_data());
      end

      // R5, R6, R10: all inputs valid, random destinations
      for (int n = 0; n < 600; n++) cycle("R5", '1, rnd_dest(), rnd_data());

      // R8: random sparse traffic
      for (int n = 0; n < 600; n++) cycle("R8", PORTS'($urandom), rnd_dest(), rnd_data());

      cycle("R4", '0, '0, '0);
      cycle("R10", '0, '0, '0);

      $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
      $finish;
   end

endmodule